// File: doc/BRIEF.md
# Video Standard Verification and Lock Controller

This block watches a 10-bit parallel video stream and confirms that its line timing agrees with a selected video standard. It then raises a lock indication that a downstream audio embedder or extractor uses to start work. The standard is a 4-bit code made of a 3-bit mode field and a TRS flag. A source-select input takes the code either from a pair of pin inputs or from a pair of host-register fields.

The block finds timing reference sequences (the words 3FF, 000, 000 and then a status word) in the stream. It measures the spacing of successive end-of-active-video references and compares that spacing with the line length the chosen code expects. After four lines in a row match, it sets a verified flag. Lock rises at the next frame start, which is a 1-to-0 change of the field bit between end-of-active-video references, as long as the flag is still set and at least one of the four audio channel enables is high. Lock does not depend on whether the chip embeds or extracts audio.

Top module: `vid_lock_ctrl`

## Requirements
- R1: When `reg_sel_i` is 0, the selected code `std_code_o` is {`pin_mode_i`, `pin_trs_i`}. When it is 1, the code is {`reg_mode_i`, `reg_trs_i`}. The output follows the inputs in the same cycle.
- R2: A reference is the word sequence 3FF, 000, 000 followed by a status word with bit 9 set. The status word marks end of active video when bit 6 (H) is 1 and carries the field bit in bit 8 (F). Other words never form a reference.
- R3: The line length is the number of clocks between successive end-of-active-video references. With the default parameters, code 0010 expects 1716 and code 1010 expects 1728.
- R4: `std_verified_o` rises at the 5th end-of-active-video reference after a clear, when the four spacings in between all match the expected length. It rises one clock after the status word is sampled.
- R5: The reserved codes 0011, 0101, 0111, 1011 and 1101 never set `std_verified_o`.
- R6: A measured spacing that differs from the expected length clears `std_verified_o` and `lock_o`. The next four spacings must all match again before the flag is set.
- R7: If no end-of-active-video reference arrives for more than two expected line periods, `std_verified_o` and `lock_o` are cleared.
- R8: Any change of the selected code clears `std_verified_o` and `lock_o`, and the measurement restarts.
- R9: `lock_o` rises only at a frame start (F goes from 1 to 0 between end-of-active-video references) while `std_verified_o` is 1 and at least one channel enable is 1. After that it stays high until the flag or the enables drop.
- R10: When all four channel enables are 0, `std_verified_o` and `lock_o` are cleared within one clock.
- R11: A synchronous active-high `rst` clears the verified flag, lock and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 10 | Parallel video word |
| reg_sel_i | input | 1 | Standard source: 0 selects pins, 1 selects register fields |
| pin_mode_i | input | 3 | Mode field from pins |
| pin_trs_i | input | 1 | TRS flag from pins |
| reg_mode_i | input | 3 | Mode field from host register |
| reg_trs_i | input | 1 | TRS flag from host register |
| chan_en_i | input | 4 | Audio channel enables |
| std_code_o | output | 4 | Selected standard code |
| std_verified_o | output | 1 | Stream matches the selected standard |
| lock_o | output | 1 | Lock indication for audio processing |

## Verification
The hardest state to reach from the ports is the restart of the four-line match run after a single bad line. The bench sends one line whose length is off by a random amount. It then sends a correct line so that the bad spacing is measured and confirms the flag has dropped. Next it sends exactly three correct lines and checks that the flag is still low, and after one more line it checks that the flag is high. A loss of references is forced by sending more than two line periods of random filler that can never form a reference.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    typedef logic [3:0] code_t;

    function automatic logic is_reserved(code_t c);
        return (c == 4'b0011) || (c == 4'b0101) || (c == 4'b0111) ||
               (c == 4'b1011) || (c == 4'b1101);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vlc_trs_detect.sv
module vlc_trs_detect #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] vid_i,
    output logic              eav_o,
    output logic              fs_o
);
    localparam int F_BIT = DATA_W - 2;
    localparam int H_BIT = DATA_W - 4;

    typedef struct packed {
        logic [DATA_W-1:0] w1;
        logic [DATA_W-1:0] w2;
        logic [DATA_W-1:0] w3;
        logic              fld;
        logic              eav;
        logic              fs;
    } trs_st_t;

    trs_st_t st_d, st_q;
    logic    hdr_hit;

    always_comb begin
        st_d    = st_q;
        hdr_hit = (st_q.w3 == {DATA_W{1'b1}}) && (st_q.w2 == '0) &&
                  (st_q.w1 == '0) && vid_i[DATA_W-1];
        st_d.w3  = st_q.w2;
        st_d.w2  = st_q.w1;
        st_d.w1  = vid_i;
        st_d.eav = hdr_hit && vid_i[H_BIT];
        st_d.fs  = hdr_hit && vid_i[H_BIT] && st_q.fld && !vid_i[F_BIT];
        if (hdr_hit && vid_i[H_BIT]) begin
            st_d.fld = vid_i[F_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign eav_o = st_q.eav;
    assign fs_o  = st_q.fs;

    AST_EAV_SPACED: assert property (@(posedge clk) disable iff (rst)
        st_q.eav |=> !st_q.eav); // R2

endmodule

// File: rtl/vlc_line_check.sv
module vlc_line_check
    import vlc_pkg::*;
#(
    parameter int LEN_525_CP = 910,
    parameter int LEN_625_CP = 1135,
    parameter int LEN_525_SD = 1716,
    parameter int LEN_625_SD = 1728,
    parameter int LEN_525_WS = 2288,
    parameter int LEN_625_WS = 2304,
    parameter int LEN_525_HR = 3432,
    parameter int LEN_625_HR = 3456,
    parameter int REQ_LINES  = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t code_i,
    input  logic  eav_i,
    input  logic  any_en_i,
    output logic  verified_o
);
    localparam int LEN_MAX = max2(max2(max2(LEN_525_CP, LEN_625_CP), max2(LEN_525_SD, LEN_625_SD)),
                                  max2(max2(LEN_525_WS, LEN_625_WS), max2(LEN_525_HR, LEN_625_HR)));
    localparam int CNT_W = $clog2(2 * LEN_MAX + 2);
    localparam int RUN_W = $clog2(REQ_LINES + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t             cnt;
        logic [RUN_W-1:0] run;
        logic             have_ref;
        logic             verified;
        code_t            code;
    } chk_st_t;

    function automatic cnt_t len_for(code_t c);
        case (c)
            4'b0000, 4'b0001: return cnt_t'(LEN_525_CP);
            4'b1000:          return cnt_t'(LEN_625_CP);
            4'b0010:          return cnt_t'(LEN_525_SD);
            4'b1010:          return cnt_t'(LEN_625_SD);
            4'b0100:          return cnt_t'(LEN_525_WS);
            4'b1100:          return cnt_t'(LEN_625_WS);
            4'b0110:          return cnt_t'(LEN_525_HR);
            4'b1110, 4'b1111: return cnt_t'(LEN_625_HR);
            default:          return '0;
        endcase
    endfunction

    chk_st_t st_d, st_q;
    cnt_t    exp_len;
    logic    timeout;
    logic    len_ok;

    always_comb begin
        st_d    = st_q;
        exp_len = len_for(code_i);
        timeout = st_q.have_ref && ({1'b0, st_q.cnt} > {exp_len, 1'b0});
        len_ok  = (exp_len != '0) && (st_q.cnt == exp_len);
        st_d.code = code_i;
        if (eav_i)                     st_d.cnt = cnt_t'(1);
        else if (st_q.cnt != '1)       st_d.cnt = st_q.cnt + cnt_t'(1);

        if ((code_i != st_q.code) || !any_en_i) begin
            st_d.cnt      = '0;
            st_d.run      = '0;
            st_d.have_ref = 1'b0;
            st_d.verified = 1'b0;
        end else if (timeout) begin
            st_d.run      = '0;
            st_d.have_ref = 1'b0;
            st_d.verified = 1'b0;
        end else if (eav_i) begin
            st_d.have_ref = 1'b1;
            if (st_q.have_ref) begin
                if (len_ok) begin
                    if (st_q.run != RUN_W'(REQ_LINES)) st_d.run = st_q.run + 1'b1;
                    if (st_q.run >= RUN_W'(REQ_LINES - 1)) st_d.verified = 1'b1;
                end else begin
                    st_d.run      = '0;
                    st_d.verified = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign verified_o = st_q.verified;

    AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (rst)
        is_reserved(code_i) |=> !st_q.verified); // R5
    AST_VERIFY_ON_EAV: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.verified) |-> $past(eav_i)); // R4
    AST_CODE_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (code_i != $past(code_i)) |=> !st_q.verified); // R8
    AST_MISMATCH_CLR: assert property (@(posedge clk) disable iff (rst)
        (eav_i && st_q.have_ref && (st_q.cnt != exp_len)) |=> !st_q.verified); // R6

endmodule

// File: rtl/vid_lock_ctrl.sv
module vid_lock_ctrl
    import vlc_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int CHAN_N     = 4,
    parameter int REQ_LINES  = 4,
    parameter int LEN_525_CP = 910,
    parameter int LEN_625_CP = 1135,
    parameter int LEN_525_SD = 1716,
    parameter int LEN_625_SD = 1728,
    parameter int LEN_525_WS = 2288,
    parameter int LEN_625_WS = 2304,
    parameter int LEN_525_HR = 3432,
    parameter int LEN_625_HR = 3456
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] vid_i,
    input  logic              reg_sel_i,
    input  logic [2:0]        pin_mode_i,
    input  logic              pin_trs_i,
    input  logic [2:0]        reg_mode_i,
    input  logic              reg_trs_i,
    input  logic [CHAN_N-1:0] chan_en_i,
    output logic [3:0]        std_code_o,
    output logic              std_verified_o,
    output logic              lock_o
);
    typedef struct packed {
        logic lock;
    } top_st_t;

    code_t   code_sel;
    logic    eav, fs, verified, any_en;
    top_st_t st_d, st_q;

    assign code_sel = reg_sel_i ? {reg_mode_i, reg_trs_i} : {pin_mode_i, pin_trs_i};
    assign any_en   = |chan_en_i;

    vlc_trs_detect #(.DATA_W(DATA_W)) u_trs (
        .clk   (clk),
        .rst   (rst),
        .vid_i (vid_i),
        .eav_o (eav),
        .fs_o  (fs)
    );

    vlc_line_check #(
        .LEN_525_CP (LEN_525_CP), .LEN_625_CP (LEN_625_CP),
        .LEN_525_SD (LEN_525_SD), .LEN_625_SD (LEN_625_SD),
        .LEN_525_WS (LEN_525_WS), .LEN_625_WS (LEN_625_WS),
        .LEN_525_HR (LEN_525_HR), .LEN_625_HR (LEN_625_HR),
        .REQ_LINES  (REQ_LINES)
    ) u_chk (
        .clk        (clk),
        .rst        (rst),
        .code_i     (code_sel),
        .eav_i      (eav),
        .any_en_i   (any_en),
        .verified_o (verified)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lock = verified && any_en && (st_q.lock || fs);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign std_code_o     = code_sel;
    assign std_verified_o = verified;
    assign lock_o         = st_q.lock;

    AST_LOCK_SOURCES: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.lock) |-> $past(fs && verified && any_en)); // R9
    AST_LOCK_NEEDS_VER: assert property (@(posedge clk) disable iff (rst)
        !verified |=> !st_q.lock); // R9
    AST_CHAN_OFF_CLR: assert property (@(posedge clk) disable iff (rst)
        !any_en |=> (!st_q.lock && !verified)); // R10

endmodule

// File: tb/sim_vid_lock_ctrl.sv
module sim_vid_lock_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] vid = 10'h200;
    logic       reg_sel = 1'b0;
    logic [2:0] pin_mode = 3'b001;
    logic       pin_trs = 1'b0;
    logic [2:0] reg_mode = 3'b000;
    logic       reg_trs = 1'b0;
    logic [3:0] chan_en = 4'b0001;
    logic [3:0] std_code;
    logic       verified, lock;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vid_lock_ctrl u0 (
        .clk(clk), .rst(rst), .vid_i(vid), .reg_sel_i(reg_sel),
        .pin_mode_i(pin_mode), .pin_trs_i(pin_trs),
        .reg_mode_i(reg_mode), .reg_trs_i(reg_trs),
        .chan_en_i(chan_en), .std_code_o(std_code),
        .std_verified_o(verified), .lock_o(lock)
    );

    function automatic int exp_len(logic [3:0] c);
        case (c)
            4'b0010: return 1716;
            4'b1010: return 1728;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic put(logic [9:0] w);
        @(negedge clk);
        vid = w;
    endtask

    function automatic logic [9:0] filler();
        return 10'h040 + 10'($urandom % 32'h380);
    endfunction

    task automatic send_line(int len, bit f);
        put(10'h3FF); put(10'h000); put(10'h000);
        put({1'b1, f, 1'b0, 1'b1, 6'b0});
        for (int i = 4; i < len - 4; i++) put(filler());
        put(10'h3FF); put(10'h000); put(10'h000);
        put({1'b1, f, 1'b0, 1'b0, 6'b0});
    endtask

    task automatic lines(int n, int len, bit f);
        for (int i = 0; i < n; i++) send_line(len, f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        int d;
        void'($urandom(32'd4711));
        pin_mode = 3'b001; pin_trs = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 verified after reset", 8'(verified), 8'd0);
        chk("R11 lock after reset", 8'(lock), 8'd0);
        chk("R1 pin code", 8'(std_code), 8'h2);

        // R3/R4: 525 component, 1716 clocks per line
        lines(4, 1716, 1'b1);
        chk("R4 not verified after 4 refs", 8'(verified), 8'd0);
        lines(1, 1716, 1'b1);
        chk("R3 verified 525", 8'(verified), 8'd1);
        chk("R9 no lock without frame start", 8'(lock), 8'd0);
        lines(1, 1716, 1'b1);
        chk("R9 no lock, field steady", 8'(lock), 8'd0);
        lines(1, 1716, 1'b0);
        chk("R9 lock at frame start", 8'(lock), 8'd1);

        // R10: all channels off
        @(negedge clk); chan_en = 4'b0000;
        @(negedge clk); @(negedge clk);
        chk("R10 verified cleared", 8'(verified), 8'd0);
        chk("R10 lock cleared", 8'(lock), 8'd0);
        chan_en = 4'(1 + ($urandom % 15));
        lines(5, 1716, 1'b1);
        chk("R10 reverified", 8'(verified), 8'd1);
        lines(1, 1716, 1'b0);
        chk("R9 relock", 8'(lock), 8'd1);

        // R6: one bad line, then run restart
        d = 1 + int'($urandom % 20);
        send_line(1716 + d, 1'b1);
        lines(1, 1716, 1'b1);
        chk("R6 mismatch clears verified", 8'(verified), 8'd0);
        chk("R6 mismatch clears lock", 8'(lock), 8'd0);
        lines(3, 1716, 1'b1);
        chk("R6 three matches not enough", 8'(verified), 8'd0);
        lines(1, 1716, 1'b1);
        chk("R6 fourth match verifies", 8'(verified), 8'd1);
        lines(1, 1716, 1'b0);
        chk("R9 lock after mismatch recovery", 8'(lock), 8'd1);

        // R8 + R1: switch to register code 1010
        @(negedge clk);
        reg_mode = 3'b101; reg_trs = 1'b0; reg_sel = 1'b1;
        #1;
        chk("R1 register code", 8'(std_code), 8'hA);
        @(negedge clk); @(negedge clk);
        chk("R8 code change clears verified", 8'(verified), 8'd0);
        chk("R8 code change clears lock", 8'(lock), 8'd0);
        lines(5, exp_len(4'b1010), 1'b1);
        chk("R3 verified 625", 8'(verified), 8'd1);
        lines(1, exp_len(4'b1010), 1'b0);
        chk("R9 lock 625", 8'(lock), 8'd1);

        // R7: references lost
        for (int i = 0; i < 2 * 1728 + 20; i++) put(filler());
        chk("R7 loss clears verified", 8'(verified), 8'd0);
        chk("R7 loss clears lock", 8'(lock), 8'd0);

        // R5: reserved code 0011
        @(negedge clk); reg_mode = 3'b001; reg_trs = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send_line(1716, i[0]);
            chk("R5 reserved never verifies", 8'(verified), 8'd0);
        end
        chk("R5 reserved no lock", 8'(lock), 8'd0);

        // random rounds on pins
        for (int it = 0; it < 2; it++) begin
            logic [3:0] c;
            c = ($urandom % 2 == 0) ? 4'b0010 : 4'b1010;
            @(negedge clk);
            reg_sel = 1'b0; pin_mode = c[3:1]; pin_trs = c[0];
            chan_en = 4'(1 + ($urandom % 15));
            #1;
            chk("R1 random pin code", 8'(std_code), 8'(c));
            lines(5, exp_len(c), 1'b1);
            chk("R4 random verify", 8'(verified), 8'd1);
            lines(1, exp_len(c), 1'b0);
            chk("R9 random lock", 8'(lock), 8'd1);
        end

        // R11: reset while locked
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R11 reset clears verified", 8'(verified), 8'd0);
        chk("R11 reset clears lock", 8'(lock), 8'd0);

        finished = 1;
        report();
        $finish;
    end
endmodule